// File: doc/BRIEF.md
# Power-Measurement Load Controller

This block turns an FPGA into an adjustable power load for board-level current measurement. Four active-low push buttons control it: one returns the demo to its start, one steps a 2-bit clock-rate code, one steps a 2-bit load-level code, and one, while held, lets the output pins toggle. The load consists of replicated stamps. Each stamp reads a pseudo-random ROM into a multiplier and shifts a signal that flips on every enabled cycle through a long shift register. The load-level code decides how many stamps run, from one stamp up to all four.

The real clock would come from a PLL. Here the clock rate is modelled as a clock enable taken from a six-phase counter, so one clock domain serves every setting. Each stamp owns a group of output pins, 16 by default, so 16, 32, 48 or 64 pins toggle as the load level rises. Both codes are shown on four LEDs. All interfaces are plain control levels, because the block has no data stream and so no back-pressure.

Top module: `pwr_load_ctrl`

## Requirements
- R1: After `arst_n` is asserted, and in every cycle while the debounced reset button is held, the rate code and the load code are 00, `led` is 0000 and every pin is low.
- R2: Each button is active low. It is synchronised through two flops, and a new level is accepted only after it has differed from the accepted level for DEB_LEN consecutive cycles. A low pulse shorter than that has no effect.
- R3: Each accepted press of the rate button adds one to the rate code, wrapping from 11 to 00. Keeping the button held does not step the code again.
- R4: Each accepted press of the load button adds one to the load code, wrapping from 11 to 00. Keeping the button held does not step the code again.
- R5: `led[3:2]` shows the load code and `led[1:0]` shows the rate code, active high.
- R6: The clock enable follows a free-running phase count from 0 to 5. It is high in every cycle for code 11, in two cycles of three for code 10 (phase mod 3 not 2), in one cycle of three for code 01 (phase mod 3 = 0) and once in six cycles for code 00 (phase 0).
- R7: Stamp k is active when k is less than or equal to the load code. An inactive stamp, or any stamp in a cycle without the clock enable, keeps its observation bit `stamp_obs[k]` unchanged.
- R8: Pin group k, which is bits [16k+15:16k], inverts on every clock-enable cycle while the output-enable button is held and stamp k is active. Otherwise the group is low.
- R9: Once the output-enable button is released and the release has been accepted, all pins are low from the next cycle on.
- R10: The reset button takes priority over the rate and load buttons when they are accepted at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| btn_rst_n | input | 1 | Reset button, active low |
| btn_freq_n | input | 1 | Rate-step button, active low |
| btn_res_n | input | 1 | Load-step button, active low |
| btn_oe_n | input | 1 | Output-enable button (hold), active low |
| led | output | 4 | {load code, rate code} |
| pins | output | N_STAMPS*PINS_PER_STAMP | Toggling load pins, one group per stamp |
| stamp_obs | output | N_STAMPS | Per-stamp parity of product and shift register |

## Verification
A button level that changes before clock edge E1 is accepted at edge E(2+DEB_LEN). The code, the LEDs and the pin gating that depend on it change one edge later, at E(3+DEB_LEN). A pin group inverts at the edge that follows each clock-enable cycle. The bench drives inputs on falling edges and runs a behavioural per-cycle model on rising edges. At each falling edge it compares `led`, `pins` and the stability of `stamp_obs` against that model. The targeted checks wait twelve cycles after each release, well past the E(3+DEB_LEN) latency, before they read a settled code. Toggle rates are counted over 30-cycle windows, which contain a whole number of six-phase periods.

// File: rtl/pwr_load_pkg.sv
package pwr_load_pkg;
  typedef logic [1:0] step_t;

  localparam int PHASES = 6;
  localparam int PH_W   = 3;

  // Enable pattern per rate code over the six-phase count
  function automatic logic rate_hit(step_t code, logic [PH_W-1:0] ph);
    logic [PH_W-1:0] m3;
    m3 = ph % 3;
    case (code)
      2'b11:   rate_hit = 1'b1;
      2'b10:   rate_hit = (m3 != 2);
      2'b01:   rate_hit = (m3 == 0);
      default: rate_hit = (ph == 0);
    endcase
  endfunction
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DEB_LEN = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic raw_n,
  output logic held,
  output logic press
);
  localparam int CW = $clog2(DEB_LEN);

  logic          s1, s2, held_d;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      held   <= 1'b0;
      held_d <= 1'b0;
      cnt    <= '0;
    end else begin
      s1     <= ~raw_n;
      s2     <= s1;
      held_d <= held;
      if (s2 != held) begin
        if (cnt == CW'(DEB_LEN - 1)) begin
          held <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  assign press = held & ~held_d;

  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    press |=> !press); // R3

  AST_HELD_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!arst_n)
    (held != $past(held)) |-> (held == $past(s2))); // R2
endmodule

// File: rtl/rate_gen.sv
module rate_gen
  import pwr_load_pkg::*;
(
  input  logic  clk,
  input  logic  arst_n,
  input  logic  clr,
  input  step_t code,
  output logic  tick
);
  logic [PH_W-1:0] ph;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                       ph <= '0;
    else if (clr)                      ph <= '0;
    else if (ph == PH_W'(PHASES - 1))  ph <= '0;
    else                               ph <= ph + 1'b1;
  end

  assign tick = ~clr & rate_hit(code, ph);
endmodule

// File: rtl/load_stamp.sv
module load_stamp #(
  parameter int ROM_AW = 5,
  parameter int DATA_W = 8,
  parameter int SR_LEN = 16,
  parameter int SEED   = 0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en,
  output logic obs
);
  localparam logic [DATA_W-1:0] COEF = DATA_W'(8'h5B + SEED * 8'h22) | DATA_W'(1);

  // Pseudo-random ROM contents, computed from the address
  function automatic logic [DATA_W-1:0] rom_val(logic [ROM_AW-1:0] a);
    logic [DATA_W-1:0] v;
    v = DATA_W'(a) * DATA_W'(8'h9D) + DATA_W'(SEED * 8'h3B + 8'h17);
    rom_val = v ^ (v >> 3) ^ DATA_W'(a << 1);
  endfunction

  logic [ROM_AW-1:0]   addr;
  logic [DATA_W-1:0]   rom_q;
  logic [2*DATA_W-1:0] prod;
  logic [SR_LEN-1:0]   sr;
  logic                tog;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      addr  <= '0;
      rom_q <= '0;
      prod  <= '0;
      sr    <= '0;
      tog   <= 1'b0;
      obs   <= 1'b0;
    end else if (en) begin
      addr  <= addr + 1'b1;
      rom_q <= rom_val(addr);
      prod  <= rom_q * COEF;
      tog   <= ~tog;
      sr    <= {sr[SR_LEN-2:0], tog};
      obs   <= (^prod) ^ (^sr);
    end
  end

  AST_IDLE_STATIC: assert property (@(posedge clk) disable iff (!arst_n)
    !en |=> $stable(obs)); // R7
endmodule

// File: rtl/pwr_load_ctrl.sv
module pwr_load_ctrl
  import pwr_load_pkg::*;
#(
  parameter int N_STAMPS       = 4,
  parameter int PINS_PER_STAMP = 16,
  parameter int ROM_AW         = 5,
  parameter int DATA_W         = 8,
  parameter int SR_LEN         = 16,
  parameter int DEB_LEN        = 16
) (
  input  logic                               clk,
  input  logic                               arst_n,
  input  logic                               btn_rst_n,
  input  logic                               btn_freq_n,
  input  logic                               btn_res_n,
  input  logic                               btn_oe_n,
  output logic [3:0]                         led,
  output logic [N_STAMPS*PINS_PER_STAMP-1:0] pins,
  output logic [N_STAMPS-1:0]                stamp_obs
);
  localparam int NB     = 4;
  localparam int B_RST  = 0;
  localparam int B_FREQ = 1;
  localparam int B_RES  = 2;
  localparam int B_OE   = 3;

  logic [NB-1:0] btn_n, held, press;
  step_t         freq_q, res_q;
  logic          tick;

  assign btn_n = {btn_oe_n, btn_res_n, btn_freq_n, btn_rst_n};

  for (genvar b = 0; b < NB; b++) begin : g_btn
    btn_debounce #(.DEB_LEN(DEB_LEN)) u_db (
      .clk   (clk),
      .arst_n(arst_n),
      .raw_n (btn_n[b]),
      .held  (held[b]),
      .press (press[b])
    );
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      freq_q <= '0;
      res_q  <= '0;
    end else if (held[B_RST]) begin
      freq_q <= '0;
      res_q  <= '0;
    end else begin
      if (press[B_FREQ]) freq_q <= freq_q + 1'b1;
      if (press[B_RES])  res_q  <= res_q + 1'b1;
    end
  end

  assign led = {res_q, freq_q};

  rate_gen u_rate (
    .clk   (clk),
    .arst_n(arst_n),
    .clr   (held[B_RST]),
    .code  (freq_q),
    .tick  (tick)
  );

  for (genvar k = 0; k < N_STAMPS; k++) begin : g_stamp
    logic                      act;
    logic [PINS_PER_STAMP-1:0] grp;

    assign act = (res_q >= 2'(k));

    load_stamp #(
      .ROM_AW(ROM_AW),
      .DATA_W(DATA_W),
      .SR_LEN(SR_LEN),
      .SEED  (k)
    ) u_stamp (
      .clk   (clk),
      .arst_n(arst_n),
      .en    (tick & act),
      .obs   (stamp_obs[k])
    );

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                                  grp <= '0;
      else if (!held[B_OE] || !act || held[B_RST])  grp <= '0;
      else if (tick)                                grp <= ~grp;
    end

    assign pins[k*PINS_PER_STAMP +: PINS_PER_STAMP] = grp;

    AST_GROUP_IDLE_LOW: assert property (@(posedge clk) disable iff (!arst_n)
      !act |=> (grp == '0 || !$stable(res_q))); // R8
  end

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!arst_n)
    held[B_RST] |=> (freq_q == 2'b00 && res_q == 2'b00 && pins == '0)); // R1

  AST_FREQ_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    (!held[B_RST] && press[B_FREQ]) |=> (freq_q == $past(freq_q) + 2'b01)); // R3

  AST_RES_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    (!held[B_RST] && press[B_RES]) |=> (res_q == $past(res_q) + 2'b01)); // R4

  AST_OE_OFF_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    !held[B_OE] |=> (pins == '0)); // R9

  AST_SLOW_RATE: assert property (@(posedge clk) disable iff (!arst_n)
    (tick && freq_q == 2'b00) |=> !tick); // R6
endmodule

// File: tb/pwr_load_ctrl_tb.sv
module pwr_load_ctrl_tb;
  localparam int NS  = 4;
  localparam int PP  = 16;
  localparam int DEB = 4;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic [3:0]    b_n = 4'hF;   // {oe, res, freq, rst}
  logic [3:0]    led;
  logic [NS*PP-1:0] pins;
  logic [NS-1:0] obs;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pwr_load_ctrl #(.N_STAMPS(NS), .PINS_PER_STAMP(PP), .DEB_LEN(DEB)) u_dut (
    .clk(clk), .arst_n(arst_n),
    .btn_rst_n(b_n[0]), .btn_freq_n(b_n[1]), .btn_res_n(b_n[2]), .btn_oe_n(b_n[3]),
    .led(led), .pins(pins), .stamp_obs(obs)
  );

  // ---------------- behavioural reference model ----------------
  int m_s1[4], m_s2[4], m_held[4], m_hd[4], m_cnt[4];
  int m_freq, m_res, m_ph;
  int m_pin[NS];
  int m_en[NS];

  function automatic int hit(int code, int ph);
    case (code)
      3: return 1;
      2: return (ph % 3 != 2) ? 1 : 0;
      1: return (ph % 3 == 0) ? 1 : 0;
      default: return (ph == 0) ? 1 : 0;
    endcase
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_held[i] = 0; m_hd[i] = 0; m_cnt[i] = 0;
      end
      m_freq = 0; m_res = 0; m_ph = 0;
      for (int i = 0; i < NS; i++) begin m_pin[i] = 0; m_en[i] = 0; end
    end else begin
      int tk, pf, pr;
      tk = (m_held[0] == 0) ? hit(m_freq, m_ph) : 0;
      pf = m_held[1] & ~m_hd[1] & 1;
      pr = m_held[2] & ~m_hd[2] & 1;
      for (int i = 0; i < NS; i++) begin
        m_en[i] = (tk == 1 && i <= m_res) ? 1 : 0;
        if (m_held[3] == 0 || i > m_res || m_held[0] == 1) m_pin[i] = 0;
        else if (tk == 1) m_pin[i] = 1 - m_pin[i];
      end
      if (m_held[0] == 1) begin
        m_freq = 0; m_res = 0; m_ph = 0;
      end else begin
        if (pf == 1) m_freq = (m_freq + 1) % 4;
        if (pr == 1) m_res = (m_res + 1) % 4;
        m_ph = (m_ph == 5) ? 0 : m_ph + 1;
      end
      for (int i = 0; i < 4; i++) begin
        m_hd[i] = m_held[i];
        if (m_s2[i] != m_held[i]) begin
          if (m_cnt[i] == DEB - 1) begin m_held[i] = m_s2[i]; m_cnt[i] = 0; end
          else m_cnt[i] = m_cnt[i] + 1;
        end else m_cnt[i] = 0;
        m_s2[i] = m_s1[i];
        m_s1[i] = b_n[i] ? 0 : 1;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison at falling edges
  logic [NS-1:0] obs_last;
  logic          live = 1'b0;
  always @(negedge clk) begin
    if (live) begin
      logic [NS*PP-1:0] ep;
      for (int i = 0; i < NS; i++) ep[i*PP +: PP] = m_pin[i] ? '1 : '0;
      check("R5 led", 64'(led), 64'({m_res[1:0], m_freq[1:0]}));
      check("R8 pins", 64'(pins), 64'(ep));
      for (int i = 0; i < NS; i++)
        if (m_en[i] == 0) check("R7 obs", 64'(obs[i]), 64'(obs_last[i]));
    end
    obs_last = obs;
  end

  task automatic press(input int b, input int hold);
    @(negedge clk); b_n[b] = 1'b0;
    repeat (hold) @(negedge clk);
    b_n[b] = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic count_toggles(input int exp, input string req);
    int n = 0;
    logic p;
    @(negedge clk); p = pins[0];
    repeat (30) begin
      @(negedge clk);
      if (pins[0] != p) n++;
      p = pins[0];
    end
    check(req, 64'(n), 64'(exp));
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    @(negedge clk);
    live = 1'b1;
    check("R1 reset led", 64'(led), 64'h0);
    check("R1 reset pins", 64'(pins), 64'h0);

    press(1, 8);
    check("R3 first step", 64'(led[1:0]), 64'd1);
    press(1, 40);
    check("R3 held no repeat", 64'(led[1:0]), 64'd2);
    press(1, 8);
    check("R3 step to 3", 64'(led[1:0]), 64'd3);
    press(1, 8);
    check("R3 wrap", 64'(led[1:0]), 64'd0);

    press(2, 3);
    check("R2 short pulse ignored", 64'(led), 64'h0);

    press(2, 8);
    check("R4 step", 64'(led[3:2]), 64'd1);
    press(1, 8);
    press(1, 8);
    check("R5 led map", 64'(led), 64'b0110);

    @(negedge clk); b_n[3] = 1'b0;
    repeat (12) @(negedge clk);
    check("R8 upper groups low", 64'(pins[63:32]), 64'h0);
    count_toggles(20, "R6 code 10");
    press(1, 8);
    count_toggles(30, "R6 code 11");
    press(2, 8);
    press(2, 8);
    check("R4 at 3", 64'(led[3:2]), 64'd3);
    press(1, 8);
    count_toggles(5, "R6 code 00");
    press(1, 8);
    count_toggles(10, "R6 code 01");
    @(negedge clk); b_n[3] = 1'b1;
    repeat (12) @(negedge clk);
    check("R9 release low", 64'(pins), 64'h0);

    press(2, 8);
    check("R4 wrap", 64'(led[3:2]), 64'd0);
    begin
      logic [NS-1:0] o0;
      o0 = obs;
      repeat (40) @(negedge clk);
      check("R7 idle stamps static", 64'(obs[3:1]), 64'(o0[3:1]));
    end

    press(2, 8);
    @(negedge clk); b_n[0] = 1'b0; b_n[1] = 1'b0;
    repeat (8) @(negedge clk);
    b_n[0] = 1'b1; b_n[1] = 1'b1;
    repeat (12) @(negedge clk);
    check("R10 reset priority", 64'(led), 64'h0);
    check("R1 pins after reset button", 64'(pins), 64'h0);

    live = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule